// File: doc/BRIEF.md
# Multi-Lane Word Deskew Aligner

This block sits behind sixteen receive lanes that share one receive clock and already deliver word-aligned parallel data, two 16-bit words per lane per cycle. It selects fourteen of those lanes with a fixed map: twelve logical data lanes, one parity lane and one clock lane. The two outermost physical lanes are dropped.

A pulse on `restart` opens a search window of `SEARCH_CYCLES` cycles. During the window each mapped lane looks for a programmable alignment word that directly follows a programmable background word, and records the word slot where it first sees it. One evaluation cycle later the lane with the earliest hit becomes the reference. Every other lane gets an align count equal to its lag in whole words behind that reference. If every lane is found within reach of the counter, `aligned` rises and the counts freeze. Each lane's output is then delayed so that words launched together on all lanes leave the block in the same output slot.

Before any successful alignment the counts are zero. Every lane then passes through the same fixed delay.

Top module: `lane_deskew_aligner`

## Requirements
- R1: Physical lane p occupies `rx_data[32p+31:32p]`, with word 0 (bits 15:0) earlier in time than word 1. Logical data lanes 0-5 come from physical lanes 1-6 and logical data lanes 6-11 from physical lanes 9-14. Physical lane 7 drives the parity output and physical lane 8 drives the clock-lane output. Logical lane l sits at `data_out[32l+31:32l]`. Physical lanes 0 and 15 reach no output and have no effect on alignment.
- R2: A lane counts a hit only where a word equal to `align_pat` directly follows a word equal to `bg_pat`. The following word may be in the same cycle or carried over from the previous cycle. An alignment word preceded by any other word is ignored.
- R3: A hit in search cycle k at word position w gets slot index 2k+w. The align count of a lane is its slot index minus the smallest slot index among the lanes that hit. Counts are packed 2 bits per logical lane in `align_cnt` (parity lane at index 12, clock lane at index 13).
- R4: With count c, output word j after the clock edge that samples input cycle t equals that lane's input word with slot index 2t+j-3+c, counting slots continuously across cycles. Lanes carrying the same content therefore line up once aligned.
- R5: If restart is sampled at edge E0, `aligned` is still low after edge E(SEARCH_CYCLES). It rises after edge E(SEARCH_CYCLES+1) when every mapped lane hit with a count of at most 3.
- R6: A mapped lane with no hit in the window sets its bit of `lane_fail`. `aligned` stays low and all counts stay zero.
- R7: A lane lagging the earliest lane by more than 3 words sets its `lane_fail` bit, and `aligned` stays low.
- R8: While `aligned` is high and no restart arrives, the counts do not change, even if fresh background and alignment words arrive.
- R9: Reset, or a restart sampled at an edge, leaves `aligned`, `lane_fail` and `align_cnt` at zero after that edge.
- R10: The alignment word is taken from the `align_pat` input. A value other than the usual 0xB496 aligns the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Clears results and starts a new search window |
| align_pat | input | 16 | Alignment word searched for |
| bg_pat | input | 16 | Background word that must precede the alignment word |
| rx_data | input | 512 | Sixteen physical lanes, 32 bits each |
| data_out | output | 384 | Twelve deskewed logical data lanes |
| parity_out | output | 32 | Deskewed parity lane |
| clklane_out | output | 32 | Deskewed clock lane |
| align_cnt | output | 28 | Per-lane align counts, 2 bits each |
| aligned | output | 1 | All mapped lanes found and deskewed |
| lane_fail | output | 14 | Per-lane search failure |

## Verification
The search is run under several lag patterns:
- All lanes level, which separates mapping errors from delay errors.
- A spread of 0 to 3 words with odd lags, which exercises hits in both word positions of a cycle.
- A spread whose earliest lane is itself late, which shows that counts are relative to that lane and not to the window start.

Error cases follow: a lane lagging by four words, and a lane whose alignment word never comes. A decoy alignment word that is not preceded by background must be skipped. The dropped edge lanes carry an early, valid-looking pattern, which would shift every count if those lanes were wrongly searched. Every output word is compared with the word the lag model predicts for its lane, which tells a wrong map, a wrong delay and a wrong count apart.

// File: rtl/deskew_pkg.sv
// Shared definitions for the lane deskew aligner.
// Assumes an even number of logical data lanes, split around the
// parity and clock lanes on the physical side.
package deskew_pkg;

    typedef enum logic [1:0] {
        SRCH_IDLE,
        SRCH_RUN,
        SRCH_EVAL,
        SRCH_HOLD
    } srch_state_t;

    // Physical lane feeding logical lane l (data lanes first, then parity, then clock).
    function automatic int phys_of(input int l, input int ndata);
        int half;
        half = ndata / 2;
        if (l < half)  return l + 1;
        if (l < ndata) return l + 3;
        if (l == ndata) return half + 1;
        return half + 2;
    endfunction

endpackage

// File: rtl/deskew_lane_map.sv
// Fixed physical-to-logical lane map.
// Assumes PHYS = DATA_LANES + 4: the outermost two physical lanes are unused.
module deskew_lane_map #(
    parameter int DATA_LANES = 12,
    parameter int LANE_W     = 32,
    localparam int PHYS      = DATA_LANES + 4,
    localparam int USED      = DATA_LANES + 2
) (
    input  logic [PHYS*LANE_W-1:0] phys_in,
    output logic [USED*LANE_W-1:0] logic_out
);

    // One wiring slice per logical lane.
    for (genvar l = 0; l < USED; l++) begin : g_map
        localparam int SRC = deskew_pkg::phys_of(l, DATA_LANES);
        assign logic_out[l*LANE_W +: LANE_W] = phys_in[SRC*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/deskew_pat_search.sv
// Per-lane search for the alignment word preceded by the background word.
// Records the first hit as a word slot index {cycle, position}.
// Assumes WPC is a power of two and at least 2.
module deskew_pat_search #(
    parameter int WORD_W = 16,
    parameter int WPC    = 2,
    parameter int CYC_W  = 4,
    localparam int POS_W   = $clog2(WPC),
    localparam int STAMP_W = CYC_W + POS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    enable,
    input  logic [CYC_W-1:0]        cyc,
    input  logic [WORD_W-1:0]       align_pat,
    input  logic [WORD_W-1:0]       bg_pat,
    input  logic [WORD_W*WPC-1:0]   din,
    output logic                    hit,
    output logic [STAMP_W-1:0]      stamp
);

    logic [WORD_W-1:0] prev_word;
    logic [WORD_W-1:0] wrd [WPC+1];
    logic              found;
    logic [POS_W-1:0]  pos;

    // Build the word sequence: last word of the previous cycle, then this cycle.
    always_comb begin
        wrd[0] = prev_word;
        for (int k = 0; k < WPC; k++) begin
            wrd[k+1] = din[k*WORD_W +: WORD_W];
        end
    end

    // Find the earliest qualified alignment word in this cycle.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int p = 0; p < WPC; p++) begin
            if (!found && wrd[p+1] == align_pat && wrd[p] == bg_pat) begin
                found = 1'b1;
                pos   = POS_W'(p);
            end
        end
    end

    // Keep the last word of each cycle for the next cycle's check.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_word <= '0;
        else        prev_word <= din[(WPC-1)*WORD_W +: WORD_W];
    end

    // Capture the first hit of the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hit   <= 1'b0;
            stamp <= '0;
        end else if (enable && !hit && found) begin
            hit   <= 1'b1;
            stamp <= {cyc, pos};
        end
    end

    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clear) |=> hit);  // R3

    AST_HIT_NEEDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> $past(enable));  // R5

endmodule

// File: rtl/deskew_word_delay.sv
// Per-lane word-granular delay line with a registered output.
// Delay in words is CNT_MAX - cnt, so the lane with the largest count
// passes with no extra words. Assumes DEPTH*WPC >= CNT_MAX + WPC.
module deskew_word_delay #(
    parameter int WORD_W = 16,
    parameter int WPC    = 2,
    parameter int CNT_W  = 2,
    parameter int DEPTH  = 3,
    localparam int LANE_W  = WORD_W * WPC,
    localparam int CNT_MAX = (1 << CNT_W) - 1,
    localparam int NWORDS  = DEPTH * WPC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);

    logic [LANE_W-1:0] hist [DEPTH-1];
    logic [WORD_W-1:0] words [NWORDS];
    logic [LANE_W-1:0] nxt;
    int                shift;

    // Shift the cycle history by one slot each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH-1; k++) hist[k] <= '0;
        end else begin
            hist[0] <= din;
            for (int k = 1; k < DEPTH-1; k++) hist[k] <= hist[k-1];
        end
    end

    // Flatten history into one word stream, oldest word first.
    always_comb begin
        for (int k = 0; k < DEPTH-1; k++) begin
            for (int j = 0; j < WPC; j++) begin
                words[k*WPC + j] = hist[DEPTH-2-k][j*WORD_W +: WORD_W];
            end
        end
        for (int j = 0; j < WPC; j++) begin
            words[(DEPTH-1)*WPC + j] = din[j*WORD_W +: WORD_W];
        end
    end

    // Pick the output words shifted back by the lane's delay.
    always_comb begin
        shift = CNT_MAX - int'(cnt);
        for (int j = 0; j < WPC; j++) begin
            nxt[j*WORD_W +: WORD_W] = words[(DEPTH-1)*WPC + j - shift];
        end
    end

    // Register the selected words.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= nxt;
    end

    AST_FULL_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_W'(CNT_MAX)) |=> (dout == $past(din)));  // R4

endmodule

// File: rtl/lane_deskew_aligner.sv
// Multi-lane word deskew aligner (top).
// Maps sixteen physical lanes to data, parity and clock lanes, finds the
// alignment word on each mapped lane inside a search window, derives per-lane
// align counts relative to the earliest lane and deskews all lanes.
// Assumes all lanes are already word aligned and share clk.
module lane_deskew_aligner #(
    parameter int DATA_LANES      = 12,
    parameter int WORD_W          = 16,
    parameter int WORDS_PER_CYCLE = 2,
    parameter int CNT_W           = 2,
    parameter int SEARCH_CYCLES   = 16,
    localparam int PHYS_LANES   = DATA_LANES + 4,
    localparam int USED_LANES   = DATA_LANES + 2,
    localparam int LANE_W       = WORD_W * WORDS_PER_CYCLE,
    localparam int CNT_MAX      = (1 << CNT_W) - 1,
    localparam int DELAY_CYCLES = (2*CNT_W + 2*WORDS_PER_CYCLE - 2) / WORDS_PER_CYCLE,
    localparam int CYC_W        = $clog2(SEARCH_CYCLES),
    localparam int STAMP_W      = CYC_W + $clog2(WORDS_PER_CYCLE)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             restart,
    input  logic [WORD_W-1:0]                align_pat,
    input  logic [WORD_W-1:0]                bg_pat,
    input  logic [PHYS_LANES*LANE_W-1:0]     rx_data,
    output logic [DATA_LANES*LANE_W-1:0]     data_out,
    output logic [LANE_W-1:0]                parity_out,
    output logic [LANE_W-1:0]                clklane_out,
    output logic [USED_LANES*CNT_W-1:0]      align_cnt,
    output logic                             aligned,
    output logic [USED_LANES-1:0]            lane_fail
);

    import deskew_pkg::*;

    srch_state_t                  state;
    logic [CYC_W-1:0]             cyc;
    logic [USED_LANES*LANE_W-1:0] mapped;
    logic [USED_LANES*LANE_W-1:0] deskewed;
    logic [USED_LANES-1:0]        hit_v;
    logic [STAMP_W-1:0]           stamp [USED_LANES];
    logic [STAMP_W-1:0]           min_stamp;
    logic [STAMP_W-1:0]           lag_full [USED_LANES];
    logic [USED_LANES-1:0]        fail_c;
    logic [USED_LANES*CNT_W-1:0]  cnt_c;
    logic [USED_LANES*CNT_W-1:0]  cnt_q;

    deskew_lane_map #(
        .DATA_LANES (DATA_LANES),
        .LANE_W     (LANE_W)
    ) u_map (
        .phys_in   (rx_data),
        .logic_out (mapped)
    );

    for (genvar l = 0; l < USED_LANES; l++) begin : g_lane
        deskew_pat_search #(
            .WORD_W (WORD_W),
            .WPC    (WORDS_PER_CYCLE),
            .CYC_W  (CYC_W)
        ) u_search (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (restart),
            .enable    (state == SRCH_RUN),
            .cyc       (cyc),
            .align_pat (align_pat),
            .bg_pat    (bg_pat),
            .din       (mapped[l*LANE_W +: LANE_W]),
            .hit       (hit_v[l]),
            .stamp     (stamp[l])
        );

        deskew_word_delay #(
            .WORD_W (WORD_W),
            .WPC    (WORDS_PER_CYCLE),
            .CNT_W  (CNT_W),
            .DEPTH  (DELAY_CYCLES)
        ) u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt   (cnt_q[l*CNT_W +: CNT_W]),
            .din   (mapped[l*LANE_W +: LANE_W]),
            .dout  (deskewed[l*LANE_W +: LANE_W])
        );
    end

    // Find the earliest hit slot among lanes that hit.
    always_comb begin
        min_stamp = '1;
        for (int l = 0; l < USED_LANES; l++) begin
            if (hit_v[l] && stamp[l] < min_stamp) min_stamp = stamp[l];
        end
    end

    // Derive per-lane lag and failure from the hit slots.
    always_comb begin
        for (int l = 0; l < USED_LANES; l++) begin
            lag_full[l] = stamp[l] - min_stamp;
            fail_c[l]   = !hit_v[l] || (lag_full[l] > STAMP_W'(CNT_MAX));
            cnt_c[l*CNT_W +: CNT_W] = lag_full[l][CNT_W-1:0];
        end
    end

    // Search window sequencing and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state     <= restart ? SRCH_RUN : SRCH_IDLE;
            cyc       <= '0;
            aligned   <= 1'b0;
            lane_fail <= '0;
            cnt_q     <= '0;
        end else begin
            case (state)
                SRCH_RUN: begin
                    if (cyc == CYC_W'(SEARCH_CYCLES-1)) state <= SRCH_EVAL;
                    else                                cyc   <= cyc + 1'b1;
                end
                SRCH_EVAL: begin
                    lane_fail <= fail_c;
                    if (fail_c == '0) begin
                        aligned <= 1'b1;
                        cnt_q   <= cnt_c;
                    end
                    state <= SRCH_HOLD;
                end
                default: state <= state;
            endcase
        end
    end

    assign data_out    = deskewed[DATA_LANES*LANE_W-1:0];
    assign parity_out  = deskewed[DATA_LANES*LANE_W +: LANE_W];
    assign clklane_out = deskewed[(DATA_LANES+1)*LANE_W +: LANE_W];
    assign align_cnt   = cnt_q;

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!aligned && lane_fail == '0 && align_cnt == '0));  // R9

    AST_COUNTS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned && !restart) |=> $stable(align_cnt));  // R8

    AST_ALIGN_NEEDS_ALL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> (&hit_v));  // R5

    AST_FAIL_FROM_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|lane_fail) |-> ($past(state) == SRCH_EVAL));  // R6

    AST_FAIL_BLOCKS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_fail != '0) |-> (!aligned && align_cnt == '0));  // R7

endmodule

// File: tb/lane_deskew_aligner_test.sv
module lane_deskew_aligner_test;

    localparam int USED = 14;
    localparam int PW   = 10;  // slot of the real alignment word in lane content

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic [15:0]   align_pat = 16'hB496;
    logic [15:0]   bg_pat = 16'h5A5A;
    logic [511:0]  rx_data = '0;
    logic [383:0]  data_out;
    logic [31:0]   parity_out;
    logic [31:0]   clklane_out;
    logic [27:0]   align_cnt;
    logic          aligned;
    logic [13:0]   lane_fail;

    lane_deskew_aligner uut (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .align_pat(align_pat), .bg_pat(bg_pat), .rx_data(rx_data),
        .data_out(data_out), .parity_out(parity_out), .clklane_out(clklane_out),
        .align_cnt(align_cnt), .aligned(aligned), .lane_fail(lane_fail)
    );

    always #4 clk = ~clk;

    int  lag [16];
    bit  miss [16];
    bit  decoy [16];
    int  t = -10;
    bit  sb_on = 1'b0;
    int  cnt_exp [USED];
    bit  exp_aligned;
    logic [13:0] exp_fail;
    int  checks = 0;
    int  fails  = 0;
    logic [USED*32-1:0] q [$];

    function automatic int phys_of(int l);
        if (l < 6)  return l + 1;
        if (l < 12) return l + 3;
        if (l == 12) return 7;
        return 8;
    endfunction

    function automatic logic [15:0] in_word(int p, int n);
        int m;
        if (p == 0 || p == 15) begin
            if (n == 2) return align_pat;
            if (n < 2)  return bg_pat;
            return 16'hDEAD ^ 16'(n);
        end
        m = n - lag[p];
        if (miss[p]) return bg_pat;
        if (decoy[p] && m == PW-5) return 16'h0001;
        if (decoy[p] && m == PW-4) return align_pat;
        if (m < PW)  return bg_pat;
        if (m == PW) return align_pat;
        return {p[3:0], m[11:0]};
    endfunction

    function automatic logic [USED*32-1:0] expect_out(int tt);
        logic [USED*32-1:0] v;
        for (int l = 0; l < USED; l++) begin
            for (int j = 0; j < 2; j++) begin
                v[l*32 + j*16 +: 16] = in_word(phys_of(l), 2*tt + j - 3 + cnt_exp[l]);
            end
        end
        return v;
    endfunction

    task automatic chk(bit ok, string msg, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", msg, act, exp);
        end
    endtask

    task automatic expect_calc();
        int minv = 1000;
        exp_aligned = 1'b1;
        exp_fail = '0;
        for (int l = 0; l < USED; l++)
            if (!miss[phys_of(l)] && lag[phys_of(l)] < minv) minv = lag[phys_of(l)];
        for (int l = 0; l < USED; l++) begin
            cnt_exp[l] = lag[phys_of(l)] - minv;
            if (miss[phys_of(l)] || cnt_exp[l] > 3) begin
                exp_fail[l] = 1'b1;
                exp_aligned = 1'b0;
            end
        end
        if (!exp_aligned) for (int l = 0; l < USED; l++) cnt_exp[l] = 0;
    endtask

    function automatic logic [27:0] pack_cnt();
        logic [27:0] v;
        for (int l = 0; l < USED; l++) v[l*2 +: 2] = 2'(cnt_exp[l]);
        return v;
    endfunction

    // Driver: applies one input cycle and pushes the expected output of that cycle.
    task automatic drive_cycle(bit rs);
        @(negedge clk);
        restart = rs;
        for (int p = 0; p < 16; p++)
            rx_data[p*32 +: 32] = {in_word(p, 2*t+1), in_word(p, 2*t)};
        if (sb_on && !rs) q.push_back(expect_out(t));
        t++;
    endtask

    // Monitor: compares each deskewed lane with the scoreboard entry.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            logic [USED*32-1:0] e, a;
            e = q.pop_front();
            a = {clklane_out, parity_out, data_out};
            for (int l = 0; l < USED; l++)
                chk(a[l*32 +: 32] == e[l*32 +: 32], $sformatf("R1/R4 lane %0d", l),
                    64'(a[l*32 +: 32]), 64'(e[l*32 +: 32]));
        end
    end

    task automatic drain();
        sb_on = 1'b0;
        repeat (2) @(posedge clk);
        #2;
    endtask

    task automatic run_align(string lbl);
        drain();
        expect_calc();
        t = -2;
        drive_cycle(0);
        drive_cycle(1);
        drive_cycle(0);
        chk(!aligned && lane_fail == 0 && align_cnt == 0, {lbl, " R9 cleared by restart"},
            {aligned, lane_fail, align_cnt}, 64'd0);
        for (int k = 1; k <= 16; k++) drive_cycle(0);
        chk(!aligned, {lbl, " R5 not early"}, 64'(aligned), 64'd0);
        @(posedge clk);
        #2;
        chk(aligned == exp_aligned, {lbl, " R5 aligned"}, 64'(aligned), 64'(exp_aligned));
        chk(lane_fail == exp_fail, {lbl, " R6/R7 lane_fail"}, 64'(lane_fail), 64'(exp_fail));
        chk(align_cnt == pack_cnt(), {lbl, " R3 counts"}, 64'(align_cnt), 64'(pack_cnt()));
        sb_on = exp_aligned;
    endtask

    task automatic set_lanes(int base, int modv, int sel);
        for (int p = 0; p < 16; p++) begin
            lag[p] = base + ((modv > 0) ? (p % modv) : 0);
            miss[p] = 1'b0;
            decoy[p] = 1'b0;
        end
        if (sel == 1) lag[3] = 4;
        if (sel == 2) miss[8] = 1'b1;
        if (sel == 3) begin decoy[4] = 1'b1; lag[4] = 1; end
    endtask

    initial begin
        #(8*200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [27:0] held;
        set_lanes(0, 0, 0);
        repeat (3) drive_cycle(0);
        chk(!aligned && lane_fail == 0 && align_cnt == 0 && data_out == 0, "R9 reset state",
            {aligned, lane_fail, align_cnt}, 64'd0);
        rst_n = 1'b1;

        set_lanes(0, 0, 0);          // level lanes
        run_align("level");
        repeat (8) drive_cycle(0);

        set_lanes(0, 4, 0);          // spread 0..3 words
        run_align("spread");
        repeat (8) drive_cycle(0);

        set_lanes(2, 3, 0);          // earliest lane itself late
        run_align("offset");
        repeat (8) drive_cycle(0);

        drain();                      // R8: fresh patterns with no restart
        held = align_cnt;
        set_lanes(1, 2, 0);
        t = -2;
        repeat (20) drive_cycle(0);
        chk(align_cnt == held && aligned, "R8 counts frozen", 64'(align_cnt), 64'(held));

        set_lanes(0, 0, 3);          // decoy without background
        run_align("R2 decoy");
        repeat (8) drive_cycle(0);

        set_lanes(0, 0, 1);          // one lane four words late
        run_align("R7 lag4");
        repeat (4) drive_cycle(0);

        set_lanes(0, 0, 2);          // clock lane never shows the pattern
        run_align("R6 missing");
        repeat (4) drive_cycle(0);

        align_pat = 16'hC3C3;        // other alignment word
        set_lanes(0, 4, 0);
        run_align("R10 pattern");
        repeat (8) drive_cycle(0);
        align_pat = 16'hB496;

        drain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule